// File: doc/BRIEF.md
# Edge Capture Channel

This block measures the timing of an external signal against a running PWM timer. It has no timebase of its own. It watches one asynchronous input pin. On each rising or falling transition it copies the present value of its PWM channel's down counter into a register kept for that edge direction. The PWM timer must therefore be set up and counting before capture is turned on. One instance pairs with each PWM channel, so a four-channel timer uses four instances, each with the same index as its channel.

The pin passes through a chain of synchronising flops before its edges are detected. A transition is therefore stamped with the counter value present on the third clock edge after the pin changes. Each edge direction has its own sticky indicator flag, which software clears by writing one. Each direction also has its own interrupt enable. The single interrupt output is raised by any flag whose enable is set. While the capture enable is low, pin activity is ignored.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, riseFlag, fallFlag and capIrq are 0, and riseVal and fallVal are all zeros.
- R2: With capEn high, a low-to-high change on capIn latches cntVal into riseVal and sets riseFlag. The value latched is the one cntVal holds just before the third rising clock edge after the pin change (synchroniser depth 2). Every such edge gives exactly one capture.
- R3: With capEn high, a high-to-low change on capIn latches cntVal into fallVal and sets fallFlag, with the same timing as R2.
- R4: A rising capture leaves fallVal and fallFlag unchanged, and a falling capture leaves riseVal and riseFlag unchanged.
- R5: capIrq is 1 exactly when (riseFlag and riseIrqEn) or (fallFlag and fallIrqEn) holds, with no added delay.
- R6: A flag stays set until its clear input (clrRise or clrFall, active high) is 1 on a clock edge, after which that flag is 0.
- R7: If a capture sets a flag on the same clock edge as its clear input is 1, the flag ends up set.
- R8: While capEn is low, pin transitions change neither latched value nor either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capIn | input | 1 | Asynchronous capture pin |
| cntVal | input | CNT_W | Running value of the paired PWM down counter |
| capEn | input | 1 | Capture enable |
| riseIrqEn | input | 1 | Interrupt enable for rising captures |
| fallIrqEn | input | 1 | Interrupt enable for falling captures |
| clrRise | input | 1 | Write-one-to-clear strobe for riseFlag |
| clrFall | input | 1 | Write-one-to-clear strobe for fallFlag |
| riseVal | output | CNT_W | Counter value latched on the last rising capture |
| fallVal | output | CNT_W | Counter value latched on the last falling capture |
| riseFlag | output | 1 | Sticky rising-capture indicator |
| fallFlag | output | 1 | Sticky falling-capture indicator |
| capIrq | output | 1 | Capture interrupt request |

## Verification
The bench builds the block with its defaults, CNT_W of 16 and SYNC_STAGES of 2. It computes the expected stamp as the counter value two decrements after the pin change. A fake counter that decrements every cycle turns any off-by-one in the synchroniser or edge latency into a wrong value. Because the width is 16, the counter can be started next to zero, and one capture lands on the wrap to 0xFFFF.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  // Strobes from the control side to the value registers.
  typedef struct packed {
    logic riseHit;
    logic fallHit;
  } capStrobe_t;
endpackage

// File: rtl/ecap_ctrl.sv
module ecap_ctrl
  import ecap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       capIn,
  input  logic       capEn,
  input  logic       riseIrqEn,
  input  logic       fallIrqEn,
  input  logic       clrRise,
  input  logic       clrFall,
  output capStrobe_t strobe,
  output logic       riseFlag,
  output logic       fallFlag,
  output logic       capIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          lvlPrev;
  logic          syncLvl;

  // Synchroniser chain, one flop per stage.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= capIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[s] <= 1'b0;
          else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  assign syncLvl = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lvlPrev <= 1'b0;
    else       lvlPrev <= syncLvl;

  // Edge strobes, gated by the enable.
  always_comb begin
    strobe.riseHit = capEn &  syncLvl & ~lvlPrev;
    strobe.fallHit = capEn & ~syncLvl &  lvlPrev;
  end

  // Sticky flags; a new capture beats a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseFlag <= 1'b0;
      fallFlag <= 1'b0;
    end else begin
      if (strobe.riseHit)  riseFlag <= 1'b1;
      else if (clrRise)    riseFlag <= 1'b0;
      if (strobe.fallHit)  fallFlag <= 1'b1;
      else if (clrFall)    fallFlag <= 1'b0;
    end
  end

  assign capIrq = (riseFlag & riseIrqEn) | (fallFlag & fallIrqEn);
endmodule

// File: rtl/ecap_dpath.sv
module ecap_dpath
  import ecap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strobe,
  input  logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] riseVal,
  output logic [CNT_W-1:0] fallVal
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseVal <= '0;
      fallVal <= '0;
    end else begin
      if (strobe.riseHit) riseVal <= cntVal;
      if (strobe.fallHit) fallVal <= cntVal;
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capIn,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             capEn,
  input  logic             riseIrqEn,
  input  logic             fallIrqEn,
  input  logic             clrRise,
  input  logic             clrFall,
  output logic [CNT_W-1:0] riseVal,
  output logic [CNT_W-1:0] fallVal,
  output logic             riseFlag,
  output logic             fallFlag,
  output logic             capIrq
);
  capStrobe_t strobe;

  ecap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .capIn(capIn), .capEn(capEn),
    .riseIrqEn(riseIrqEn), .fallIrqEn(fallIrqEn),
    .clrRise(clrRise), .clrFall(clrFall), .strobe(strobe),
    .riseFlag(riseFlag), .fallFlag(fallFlag), .capIrq(capIrq)
  );

  ecap_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntVal(cntVal),
    .riseVal(riseVal), .fallVal(fallVal)
  );
endmodule

// File: rtl/edge_capture_sva.sv
module edge_capture_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             capEn,
  input logic             riseIrqEn,
  input logic             fallIrqEn,
  input logic             clrRise,
  input logic             clrFall,
  input logic [CNT_W-1:0] riseVal,
  input logic [CNT_W-1:0] fallVal,
  input logic             riseFlag,
  input logic             fallFlag,
  input logic             capIrq
);
  // R2: a new rising value is always accompanied by its flag
  a_r2_val_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (riseVal != $past(riseVal)) |-> riseFlag);
  // R3
  a_r3_val_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (fallVal != $past(fallVal)) |-> fallFlag);
  // R4: only one direction can be captured per edge
  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(riseFlag) && $rose(fallFlag)));
  // R5
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |-> (riseFlag || fallFlag));
  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!riseIrqEn && !fallIrqEn) |-> !capIrq);
  // R6
  a_r6_rise_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (riseFlag && !clrRise) |=> riseFlag);
  a_r6_fall_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (fallFlag && !clrFall) |=> fallFlag);
  a_r6_rise_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrRise && !capEn) |=> !riseFlag);
  a_r6_fall_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrFall && !capEn) |=> !fallFlag);
  // R8
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !capEn |=> ($stable(riseVal) && $stable(fallVal)
                && !$rose(riseFlag) && !$rose(fallFlag)));
endmodule

bind edge_capture_unit edge_capture_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rstN(rstN), .capEn(capEn),
  .riseIrqEn(riseIrqEn), .fallIrqEn(fallIrqEn),
  .clrRise(clrRise), .clrFall(clrFall),
  .riseVal(riseVal), .fallVal(fallVal),
  .riseFlag(riseFlag), .fallFlag(fallFlag), .capIrq(capIrq)
);

// File: tb/edge_capture_unit_test.sv
`timescale 1ns/1ps
module edge_capture_unit_test;
  localparam int CW = 16;
  localparam int SY = 2;

  logic clk = 1'b0, rstN = 1'b0, capIn = 1'b0, capEn = 1'b0;
  logic riseIrqEn = 1'b0, fallIrqEn = 1'b0, clrRise = 1'b0, clrFall = 1'b0;
  logic [CW-1:0] cntVal = 16'h0040;
  logic [CW-1:0] riseVal, fallVal;
  logic riseFlag, fallFlag, capIrq;

  edge_capture_unit #(.CNT_W(CW), .SYNC_STAGES(SY)) uut (
    .clk(clk), .rstN(rstN), .capIn(capIn), .cntVal(cntVal), .capEn(capEn),
    .riseIrqEn(riseIrqEn), .fallIrqEn(fallIrqEn),
    .clrRise(clrRise), .clrFall(clrFall),
    .riseVal(riseVal), .fallVal(fallVal),
    .riseFlag(riseFlag), .fallFlag(fallFlag), .capIrq(capIrq)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic isRise; logic [CW-1:0] val; } expItem_t;
  expItem_t expQ[$];
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cntVal = cntVal - 1'b1;
  endtask

  // Driver: change the pin and push the expected stamp if capture is on.
  task automatic drivePin(input logic lvl);
    expItem_t it;
    if (capEn && (lvl != capIn)) begin
      it.isRise = lvl;
      it.val    = CW'(cntVal - SY);
      expQ.push_back(it);
    end
    capIn = lvl;
    repeat (SY + 2) tick();
  endtask

  task automatic clearFlags();
    clrRise = 1'b1; clrFall = 1'b1;
    tick();
    clrRise = 1'b0; clrFall = 1'b0;
    tick();
  endtask

  // Monitor: pop one expected item whenever a flag newly rises.
  task automatic popCheck(input logic isRise, input logic [CW-1:0] got);
    expItem_t it;
    if (expQ.size() == 0) begin
      check(1'b0, "R8", "unexpected capture", 32'(got), 32'hx);
    end else begin
      it = expQ.pop_front();
      check(it.isRise == isRise, "R4", "capture direction", 32'(isRise), 32'(it.isRise));
      check(it.val == got, isRise ? "R2" : "R3", "latched value", 32'(got), 32'(it.val));
    end
  endtask

  logic seenR = 1'b0, seenF = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (riseFlag && !seenR) popCheck(1'b1, riseVal);
      if (fallFlag && !seenF) popCheck(1'b0, fallVal);
    end
    seenR = riseFlag;
    seenF = fallFlag;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] rv, fv;
    logic lvl;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!riseFlag && !fallFlag, "R1", "flags", {riseFlag, fallFlag}, 0);
    check(riseVal == 0 && fallVal == 0, "R1", "values", {riseVal, fallVal}, 0);
    check(!capIrq, "R1", "capIrq", capIrq, 0);
    rstN = 1'b1;
    capEn = 1'b1;
    tick();

    // R2 rising capture, irq masked
    drivePin(1'b1);
    check(riseFlag, "R2", "riseFlag", riseFlag, 1);
    check(!fallFlag && fallVal == 0, "R4", "fall side untouched", {fallFlag, fallVal}, 0);
    check(!capIrq, "R5", "irq with enables off", capIrq, 0);
    riseIrqEn = 1'b1; #0.1;
    check(capIrq, "R5", "irq rise enabled", capIrq, 1);
    riseIrqEn = 1'b0; fallIrqEn = 1'b1; #0.1;
    check(!capIrq, "R5", "irq other enable only", capIrq, 0);
    repeat (6) tick();
    check(riseFlag, "R6", "flag sticky", riseFlag, 1);
    clrRise = 1'b1; tick(); clrRise = 1'b0;
    check(!riseFlag, "R6", "riseFlag cleared", riseFlag, 0);

    // R3 falling capture, irq enabled
    rv = riseVal;
    drivePin(1'b0);
    check(fallFlag, "R3", "fallFlag", fallFlag, 1);
    check(!riseFlag && riseVal == rv, "R4", "rise side untouched", {riseFlag, riseVal}, {1'b0, rv});
    check(capIrq, "R5", "irq fall enabled", capIrq, 1);
    clearFlags();
    check(!fallFlag && !capIrq, "R6", "fall cleared, irq low", {fallFlag, capIrq}, 0);

    // R2/R3 several patterns, including counter wrap
    cntVal = 16'h0001;
    for (int i = 0; i < 6; i++) begin
      drivePin(~capIn);
      repeat (i) tick();
      clearFlags();
    end
    cntVal = 16'hA5C3;
    drivePin(~capIn);
    clearFlags();

    // R7 set beats clear on the same edge
    lvl = ~capIn;
    begin
      expItem_t it;
      it.isRise = lvl; it.val = CW'(cntVal - SY);
      expQ.push_back(it);
    end
    capIn = lvl;
    repeat (SY) tick();
    clrRise = 1'b1; clrFall = 1'b1;
    tick();
    clrRise = 1'b0; clrFall = 1'b0;
    tick();
    check(lvl ? riseFlag : fallFlag, "R7", "flag after set+clear", lvl ? riseFlag : fallFlag, 1);
    clearFlags();

    // R8 disabled capture ignores pin
    capEn = 1'b0;
    rv = riseVal; fv = fallVal;
    drivePin(~capIn);
    drivePin(~capIn);
    check(!riseFlag && !fallFlag, "R8", "flags while disabled", {riseFlag, fallFlag}, 0);
    check(riseVal == rv && fallVal == fv, "R8", "values while disabled",
          {riseVal, fallVal}, {rv, fv});
    capEn = 1'b1;
    tick();
    drivePin(~capIn);
    clearFlags();

    repeat (4) tick();
    check(expQ.size() == 0, "R2", "all expected captures seen", expQ.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule